// File: doc/BRIEF.md
# Ready-Gated Register Command Master

This block sits on the controller side of a synchronous, address-mapped register port and turns single user requests into port commands. A user request carries a read/write flag, an address, a byte-enable mask and write data. It is handed over on a req/ack pair and is accepted only while the block is idle. The far side of the port samples commands in a slower clock domain, so its ready signal is a sparse single-cycle pulse, typically one cycle in eight. That pulse may arrive before the block has anything to send.

The block remembers a ready pulse in a one-shot flag. It issues a one-cycle command-valid once the flag is set, and clears the flag with that issue so that no pulse serves two commands. A write finishes as soon as it is issued, because the port gives no reply to writes. A read keeps the block busy until the port's read-data valid has risen and then fallen again. During that window every ready pulse is discarded. The block raises accept in the cycle it takes the read data, then hands the data to the user with a one-cycle response strobe.

Top module: `regcmd_master`

## Requirements
- R1: While reset is high and in the first cycle after it, prt_valid, prt_accept, usr_ack and usr_rvalid are all 0.
- R2: A request is taken only when the block is idle. usr_ack goes high for exactly one cycle in the cycle after the request is taken. A request held while a command is still in progress gets no ack and does not change the fields of the pending command.
- R3: prt_valid never rises unless a ready pulse has been sampled since the previous command. When a request is already waiting, prt_valid is high in the second cycle after the clock edge that samples prt_ready.
- R4: prt_valid is high for exactly one cycle per command. In that cycle prt_we (1 = write, 0 = read), prt_addr, prt_mask and prt_wdata hold the values of the request.
- R5: A ready pulse that arrives while the block is idle is remembered. The next request is issued without waiting for another pulse.
- R6: One ready pulse lets through at most one command. A second request waits for a fresh pulse.
- R7: Once a read is issued, no command of any kind is issued until prt_rvalid has been high and then low again. Ready pulses sampled during that window are ignored, so a command that follows the read needs a new pulse.
- R8: prt_accept is high only in the cycle in which prt_rvalid is high while the block waits for read data. It is high for one cycle per read and stays low if prt_rvalid is held high afterwards.
- R9: usr_rvalid is high for one cycle, in the cycle after prt_accept, with usr_rdata equal to the prt_rdata value present when prt_accept was high.
- R10: A write needs no reply. The block is idle again one cycle after the write's prt_valid cycle and can take a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every port signal is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| usr_req | input | 1 | User request strobe, held until usr_ack |
| usr_we | input | 1 | Request type: 1 = write, 0 = read |
| usr_addr | input | ADDR_W | Register address |
| usr_mask | input | DATA_W/8 | Byte enables for a write |
| usr_wdata | input | DATA_W | Write data |
| usr_ack | output | 1 | One-cycle pulse: request taken |
| usr_rvalid | output | 1 | One-cycle pulse: usr_rdata holds read data |
| usr_rdata | output | DATA_W | Returned read data |
| prt_ready | input | 1 | Sparse ready pulse from the register port |
| prt_valid | output | 1 | One-cycle command strobe |
| prt_we | output | 1 | Command type: 1 = write, 0 = read |
| prt_addr | output | ADDR_W | Command address |
| prt_mask | output | DATA_W/8 | Command byte enables |
| prt_wdata | output | DATA_W | Command write data |
| prt_rvalid | input | 1 | Read data valid from the port |
| prt_rdata | input | DATA_W | Read data from the port |
| prt_accept | output | 1 | Read data taken |

## Verification
Several properties are checked on every cycle: the one-cycle width of command-valid, accept and the user strobes; that no command goes out without a ready pulse since the last one; and that no command goes out while a read is open. These checks use a small shadow model built from the port pins only. Some behaviour can only be shown by the bench's directed scenarios. These are the exact two-cycle delay from a ready pulse to the command, a pulse remembered from idle, the field values carried by each command, a held request being refused, the read data reaching the user, and a stray pulse during a read being discarded, which only shows up as a stalled write afterwards.

// File: rtl/regcmd_pkg.sv
`timescale 1ns/1ps
package regcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WAIT_RDY = 3'd1,
        ST_ISSUE    = 3'd2,
        ST_RD_WAIT  = 3'd3,
        ST_RD_DRAIN = 3'd4
    } seq_state_e;

    function automatic int mask_width(input int data_w);
        return (data_w + 7) / 8;
    endfunction

    // A read is open from its issue cycle until read-data valid has dropped.
    function automatic logic read_open(input seq_state_e st, input logic we);
        return (st == ST_ISSUE && !we) || (st == ST_RD_WAIT) || (st == ST_RD_DRAIN);
    endfunction

endpackage

// File: rtl/regcmd_rdy_track.sv
`timescale 1ns/1ps
module regcmd_rdy_track (
    input  logic clk,
    input  logic rst,
    input  logic prt_ready,
    input  logic block,
    input  logic consume,
    output logic seen
);
    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
        end else if (consume) begin
            seen <= 1'b0;
        end else if (prt_ready && !block) begin
            seen <= 1'b1;
        end
    end
endmodule

// File: rtl/regcmd_seq.sv
`timescale 1ns/1ps
module regcmd_seq #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic                                          usr_req,
    input  logic                                          usr_we,
    input  logic [ADDR_W-1:0]                             usr_addr,
    input  logic [regcmd_pkg::mask_width(DATA_W)-1:0]     usr_mask,
    input  logic [DATA_W-1:0]                             usr_wdata,
    input  logic                                          rdy_seen,
    input  logic                                          prt_rvalid,
    output regcmd_pkg::seq_state_e                        state,
    output logic                                          usr_ack,
    output logic                                          prt_valid,
    output logic                                          prt_we,
    output logic [ADDR_W-1:0]                             prt_addr,
    output logic [regcmd_pkg::mask_width(DATA_W)-1:0]     prt_mask,
    output logic [DATA_W-1:0]                             prt_wdata,
    output logic                                          consume,
    output logic                                          rd_take
);
    import regcmd_pkg::*;

    localparam int MASK_W = mask_width(DATA_W);

    seq_state_e state_nx;
    logic       take_req;

    assign take_req  = (state == ST_IDLE) && usr_req;
    assign consume   = (state == ST_WAIT_RDY) && rdy_seen;
    assign prt_valid = (state == ST_ISSUE);
    assign rd_take   = (state == ST_RD_WAIT) && prt_rvalid;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (usr_req)     state_nx = ST_WAIT_RDY;
            ST_WAIT_RDY: if (rdy_seen)    state_nx = ST_ISSUE;
            ST_ISSUE:    state_nx = prt_we ? ST_IDLE : ST_RD_WAIT;
            ST_RD_WAIT:  if (prt_rvalid)  state_nx = ST_RD_DRAIN;
            ST_RD_DRAIN: if (!prt_rvalid) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            usr_ack   <= 1'b0;
            prt_we    <= 1'b0;
            prt_addr  <= '0;
            prt_mask  <= '0;
            prt_wdata <= '0;
        end else begin
            state   <= state_nx;
            usr_ack <= take_req;
            if (take_req) begin
                prt_we    <= usr_we;
                prt_addr  <= usr_addr;
                prt_mask  <= usr_mask[MASK_W-1:0];
                prt_wdata <= usr_wdata;
            end
        end
    end
endmodule

// File: rtl/regcmd_rd_capture.sv
`timescale 1ns/1ps
module regcmd_rd_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic [DATA_W-1:0] prt_rdata,
    output logic              usr_rvalid,
    output logic [DATA_W-1:0] usr_rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            usr_rvalid <= 1'b0;
            usr_rdata  <= '0;
        end else begin
            usr_rvalid <= take;
            if (take) begin
                usr_rdata <= prt_rdata;
            end
        end
    end
endmodule

// File: rtl/regcmd_master.sv
`timescale 1ns/1ps
module regcmd_master #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      usr_req,
    input  logic                                      usr_we,
    input  logic [ADDR_W-1:0]                         usr_addr,
    input  logic [regcmd_pkg::mask_width(DATA_W)-1:0] usr_mask,
    input  logic [DATA_W-1:0]                         usr_wdata,
    output logic                                      usr_ack,
    output logic                                      usr_rvalid,
    output logic [DATA_W-1:0]                         usr_rdata,
    input  logic                                      prt_ready,
    output logic                                      prt_valid,
    output logic                                      prt_we,
    output logic [ADDR_W-1:0]                         prt_addr,
    output logic [regcmd_pkg::mask_width(DATA_W)-1:0] prt_mask,
    output logic [DATA_W-1:0]                         prt_wdata,
    input  logic                                      prt_rvalid,
    input  logic [DATA_W-1:0]                         prt_rdata,
    output logic                                      prt_accept
);
    import regcmd_pkg::*;

    seq_state_e state;
    logic       rdy_seen;
    logic       consume;
    logic       rd_take;
    logic       rd_block;

    assign rd_block   = read_open(state, prt_we);
    assign prt_accept = rd_take;

    regcmd_rdy_track u_rdy (
        .clk       (clk),
        .rst       (rst),
        .prt_ready (prt_ready),
        .block     (rd_block),
        .consume   (consume),
        .seen      (rdy_seen)
    );

    regcmd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .usr_req    (usr_req),
        .usr_we     (usr_we),
        .usr_addr   (usr_addr),
        .usr_mask   (usr_mask),
        .usr_wdata  (usr_wdata),
        .rdy_seen   (rdy_seen),
        .prt_rvalid (prt_rvalid),
        .state      (state),
        .usr_ack    (usr_ack),
        .prt_valid  (prt_valid),
        .prt_we     (prt_we),
        .prt_addr   (prt_addr),
        .prt_mask   (prt_mask),
        .prt_wdata  (prt_wdata),
        .consume    (consume),
        .rd_take    (rd_take)
    );

    regcmd_rd_capture #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk        (clk),
        .rst        (rst),
        .take       (rd_take),
        .prt_rdata  (prt_rdata),
        .usr_rvalid (usr_rvalid),
        .usr_rdata  (usr_rdata)
    );
endmodule

// File: rtl/regcmd_master_chk.sv
`timescale 1ns/1ps
module regcmd_master_chk (
    input logic clk,
    input logic rst,
    input logic prt_ready,
    input logic prt_valid,
    input logic prt_we,
    input logic prt_rvalid,
    input logic prt_accept,
    input logic usr_ack,
    input logic usr_rvalid
);
    // Shadow model built from pins only
    logic sh_rdy;
    logic sh_busy;
    logic sh_rv_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_rdy     <= 1'b0;
            sh_busy    <= 1'b0;
            sh_rv_seen <= 1'b0;
        end else begin
            if (prt_valid) begin
                sh_rdy <= prt_ready && prt_we;
            end else if (prt_ready && !sh_busy) begin
                sh_rdy <= 1'b1;
            end
            if (prt_valid && !prt_we) begin
                sh_busy    <= 1'b1;
                sh_rv_seen <= 1'b0;
            end else if (sh_busy && sh_rv_seen && !prt_rvalid) begin
                sh_busy    <= 1'b0;
                sh_rv_seen <= 1'b0;
            end else if (sh_busy && prt_rvalid) begin
                sh_rv_seen <= 1'b1;
            end
        end
    end

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        prt_valid |=> !prt_valid);                       // R4
    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        prt_valid |-> sh_rdy);                           // R3
    AST_NO_CMD_IN_READ: assert property (@(posedge clk) disable iff (rst)
        sh_busy |-> !prt_valid);                         // R7
    AST_ACCEPT_WITH_RVALID: assert property (@(posedge clk) disable iff (rst)
        prt_accept |-> (prt_rvalid && sh_busy));         // R8
    AST_ACCEPT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        prt_accept |=> !prt_accept);                     // R8
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        usr_ack |=> !usr_ack);                           // R2
    AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        usr_rvalid |-> $past(prt_accept));               // R9
endmodule

bind regcmd_master regcmd_master_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .prt_ready  (prt_ready),
    .prt_valid  (prt_valid),
    .prt_we     (prt_we),
    .prt_rvalid (prt_rvalid),
    .prt_accept (prt_accept),
    .usr_ack    (usr_ack),
    .usr_rvalid (usr_rvalid)
);

// File: tb/tb_regcmd_master.sv
`timescale 1ns/1ps
module tb_regcmd_master;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int MW = DW / 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          usr_req = 1'b0;
    logic          usr_we = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic [MW-1:0] usr_mask = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic          usr_ack;
    logic          usr_rvalid;
    logic [DW-1:0] usr_rdata;
    logic          prt_ready = 1'b0;
    logic          prt_valid;
    logic          prt_we;
    logic [AW-1:0] prt_addr;
    logic [MW-1:0] prt_mask;
    logic [DW-1:0] prt_wdata;
    logic          prt_rvalid = 1'b0;
    logic [DW-1:0] prt_rdata = '0;
    logic          prt_accept;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int vcount = 0;
    int vrun = 0;
    int vrun_max = 0;
    int v_cyc = 0;
    int rdy_cyc = 0;
    int phase = 0;
    bit rdy_auto = 1'b0;
    logic          v_we = 1'b0;
    logic [AW-1:0] v_addr = '0;
    logic [MW-1:0] v_mask = '0;
    logic [DW-1:0] v_wdata = '0;

    always #2.5 clk = ~clk;

    regcmd_master #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst),
        .usr_req(usr_req), .usr_we(usr_we), .usr_addr(usr_addr),
        .usr_mask(usr_mask), .usr_wdata(usr_wdata),
        .usr_ack(usr_ack), .usr_rvalid(usr_rvalid), .usr_rdata(usr_rdata),
        .prt_ready(prt_ready), .prt_valid(prt_valid), .prt_we(prt_we),
        .prt_addr(prt_addr), .prt_mask(prt_mask), .prt_wdata(prt_wdata),
        .prt_rvalid(prt_rvalid), .prt_rdata(prt_rdata), .prt_accept(prt_accept)
    );

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Port monitor: records each command strobe
    initial forever begin
        @(negedge clk);
        if (prt_valid) begin
            if (vrun == 0) begin
                vcount++;
                v_cyc   = cyc;
                v_we    = prt_we;
                v_addr  = prt_addr;
                v_mask  = prt_mask;
                v_wdata = prt_wdata;
            end
            vrun++;
            if (vrun > vrun_max) vrun_max = vrun;
        end else begin
            vrun = 0;
        end
    end

    // Free-running one-in-eight ready source
    initial forever begin
        @(negedge clk);
        phase++;
        if (rdy_auto) prt_ready = (phase % 8 == 0);
    end

    task automatic chk_eq(input string r, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic pulse_ready();
        @(negedge clk);
        prt_ready = 1'b1;
        rdy_cyc   = cyc;
        @(negedge clk);
        prt_ready = 1'b0;
    endtask

    task automatic user_req(input logic we, input logic [AW-1:0] a,
                            input logic [MW-1:0] m, input logic [DW-1:0] d);
        @(negedge clk);
        usr_req = 1'b1; usr_we = we; usr_addr = a; usr_mask = m; usr_wdata = d;
        do @(negedge clk); while (!usr_ack);
        usr_req = 1'b0;
        @(negedge clk);
        chk_eq("R2 ack lasts one cycle", usr_ack, 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input int dly, input bit extra);
        int c0 = vcount;
        int bad = 0;
        user_req(1'b0, a, '1, '0);
        while (vcount == c0) @(negedge clk);
        chk_eq("R4 read flag", v_we, 0);
        chk_eq("R4 read address", v_addr, a);
        if (extra) pulse_ready();
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            if (prt_accept || prt_valid) bad++;
        end
        chk_eq("R8 no accept before rvalid", bad, 0);
        prt_rvalid = 1'b1;
        prt_rdata  = d;
        #1;
        chk_eq("R8 accept with rvalid", prt_accept, 1);
        @(negedge clk);
        chk_eq("R9 response strobe", usr_rvalid, 1);
        chk_eq("R9 response data", usr_rdata, d);
        chk_eq("R8 accept one cycle", prt_accept, 0);
        repeat (2) @(negedge clk);
        chk_eq("R9 strobe one cycle", usr_rvalid, 0);
        prt_rvalid = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R7 no command during read", vcount, c0 + 1);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk_eq("R1 valid in reset", prt_valid, 0);
        chk_eq("R1 accept in reset", prt_accept, 0);
        chk_eq("R1 ack in reset", usr_ack, 0);
        chk_eq("R1 rvalid in reset", usr_rvalid, 0);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 valid after reset", prt_valid, 0);
        chk_eq("R1 ack after reset", usr_ack, 0);
    endtask

    task automatic test_early_ready();
        int c0 = vcount;
        pulse_ready();
        repeat (3) @(negedge clk);
        user_req(1'b1, 16'h0012, 4'b0101, 32'hA5A5_0001);
        repeat (4) @(negedge clk);
        chk_eq("R5 remembered pulse issues", vcount, c0 + 1);
        chk_eq("R4 write flag", v_we, 1);
        chk_eq("R4 address", v_addr, 16'h0012);
        chk_eq("R4 mask", v_mask, 4'b0101);
        chk_eq("R4 wdata", v_wdata, 32'hA5A5_0001);
        chk_eq("R4 valid width", vrun_max, 1);
    endtask

    task automatic test_wait_ready();
        int c0 = vcount;
        user_req(1'b1, 16'h0034, 4'hF, 32'h1234_5678);
        repeat (10) @(negedge clk);
        chk_eq("R3 no command without ready", vcount, c0);
        pulse_ready();
        repeat (3) @(negedge clk);
        chk_eq("R3 command after ready", vcount, c0 + 1);
        chk_eq("R3 ready-to-valid delay", v_cyc - rdy_cyc, 2);
    endtask

    task automatic test_one_pulse_one_cmd();
        int c0 = vcount;
        int ackbad = 0;
        user_req(1'b1, 16'h00A0, 4'h3, 32'h0000_00A0);
        @(negedge clk);
        usr_req = 1'b1; usr_we = 1'b1; usr_addr = 16'h00B0;
        usr_mask = 4'hC; usr_wdata = 32'h0000_00B0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (usr_ack) ackbad++;
        end
        chk_eq("R2 no ack while busy", ackbad, 0);
        pulse_ready();
        while (!usr_ack) @(negedge clk);
        usr_req = 1'b0;
        repeat (10) @(negedge clk);
        chk_eq("R6 one pulse one command", vcount, c0 + 1);
        chk_eq("R2 pending fields kept", v_addr, 16'h00A0);
        chk_eq("R2 pending data kept", v_wdata, 32'h0000_00A0);
        pulse_ready();
        repeat (3) @(negedge clk);
        chk_eq("R10 next write issues", vcount, c0 + 2);
        chk_eq("R10 next write address", v_addr, 16'h00B0);
        chk_eq("R10 next write mask", v_mask, 4'hC);
    endtask

    task automatic test_read_blocks();
        int c0 = vcount;
        pulse_ready();
        do_read(16'h0056, 32'hDEAD_BEEF, 5, 1'b1);
        user_req(1'b1, 16'h0078, 4'hF, 32'h7878_7878);
        repeat (12) @(negedge clk);
        chk_eq("R7 stray pulse ignored", vcount, c0 + 1);
        pulse_ready();
        repeat (3) @(negedge clk);
        chk_eq("R7 write after fresh pulse", vcount, c0 + 2);
        chk_eq("R7 write address", v_addr, 16'h0078);
    endtask

    task automatic test_auto_stream();
        rdy_auto = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (i % 2 == 0) begin
                int c0 = vcount;
                user_req(1'b1, 16'(16'h0100 + i), 4'h9, 32'hC0DE_0000 + i);
                while (vcount == c0) @(negedge clk);
                chk_eq("R4 stream address", v_addr, 16'h0100 + i);
                chk_eq("R4 stream wdata", v_wdata, 32'hC0DE_0000 + i);
            end else begin
                do_read(16'(16'h0200 + i), 32'hBEEF_0000 + i, 3, 1'b0);
            end
        end
        rdy_auto  = 1'b0;
        prt_ready = 1'b0;
        chk_eq("R4 valid width in stream", vrun_max, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_early_ready();
        test_wait_ready();
        test_one_pulse_one_cmd();
        test_read_blocks();
        test_auto_stream();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule